// File: doc/BRIEF.md
# Overlapped Two-Phase Micro-Op Datapath

This block is the register-and-bus datapath of a small microcoded 8-bit processor. Each clock cycle the sequencer presents one microinstruction word. Its first phase loads one of two ALU operand latches, T1 or T2. The source is either a 16-entry register bank or the raw, unregistered data-input bus. Its second phase runs one cycle later, while the next microinstruction is in its own first phase. In that second phase the block hands the delayed ALU opcode and the operand latches to an external ALU. It then writes the ALU result back into the bank or into a held data-output register. The address, read, write and IO strobes of the memory bus are produced here as well. A low-byte address latch is filled by one microinstruction, and a later one combines it with the bank output to form the 16-bit address.

Each microinstruction carries a single register selector, used to read in phase 1 and again, delayed, to write in phase 2. So one microinstruction can never touch two different bank entries. The bus and sequencer interfaces have fixed cycle timing and no back-pressure, so every pin is a plain control or data pin without a valid/ready handshake. The microcode may not stall a phase in progress.

Top module: `twophase_datapath`

## Requirements
- R1: During and after reset, t1, t2, dout, addr, alu_op and inte read zero, all strobes are low, and every bank entry is zero.
- R2: Source code ui_src 1 loads T1 from bank[ui_reg], 2 loads T2 from bank[ui_reg], 3 loads T1 from din, and 0 loads nothing. The load happens at the clock edge that ends the microinstruction's first cycle, and the other latch keeps its value.
- R3: During the cycle after a microinstruction is issued, alu_op shows that microinstruction's ui_aluop. At the end of that cycle, destination code ui_dst 1 writes alu_res into bank[ui_reg of that same microinstruction].
- R4: A bank entry written by the phase 2 of microinstruction N still reads its old value in phase 1 of N+1, and reads the new value from N+2 on.
- R5: Destination code ui_dst 2 loads dout with alu_res at the end of the second cycle. dout keeps its value through any microinstruction whose destination is not 2.
- R6: ui_ld_al captures bank[ui_reg] into the low-address latch at the end of the first cycle. ui_ld_addr drives addr = {bank[ui_reg], latch} in its first cycle, and addr holds that value afterwards.
- R7: vma and io are high in the microinstruction's first cycle. rd and wr are high in its second cycle.
- R8: ui_clrt1 sets T1 to zero at the end of the first cycle, and it overrides a T1 load in the same microinstruction.
- R9: ui_ei sets inte at the end of the first cycle and ui_di clears it. If both are given together, inte is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ui_src | input | 2 | Phase-1 operand source code |
| ui_reg | input | 4 | Bank entry for this microinstruction, both phases |
| ui_dst | input | 2 | Phase-2 destination: 0 none, 1 bank, 2 dout |
| ui_aluop | input | 4 | ALU opcode, forwarded in phase 2 |
| ui_ld_al | input | 1 | Capture bank output into low-address latch |
| ui_ld_addr | input | 1 | Form and drive the 16-bit address |
| ui_rd | input | 1 | Memory read request |
| ui_wr | input | 1 | Memory write request |
| ui_io | input | 1 | IO-space access |
| ui_clrt1 | input | 1 | Clear T1 |
| ui_ei | input | 1 | Set interrupt enable |
| ui_di | input | 1 | Clear interrupt enable |
| din | input | 8 | Unregistered data-input bus |
| alu_res | input | 8 | Result from the external ALU |
| t1 | output | 8 | Operand latch T1 |
| t2 | output | 8 | Operand latch T2 |
| alu_op | output | 4 | Opcode of the microinstruction in phase 2 |
| addr | output | 16 | Bus address |
| vma | output | 1 | Valid memory address strobe |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| io | output | 1 | IO strobe |
| dout | output | 8 | Output data register |
| inte | output | 1 | Interrupt-enable register |

## Verification
The hardest situation to reach from the ports is the write-visibility hazard. It needs a bank write in flight in phase 2 while the very next microinstruction reads the same entry. The bench issues a din-to-T1-to-bank transfer and follows it back to back with two reads of that entry into T2. The first read must return the old contents and the second the new ones. Bank contents are only visible through the operand latches, so every bank check ends by routing the entry into T2 and observing it at the port.

// File: rtl/twophase_pkg.sv
package twophase_pkg;
  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_T1_BANK = 2'd1,
    SRC_T2_BANK = 2'd2,
    SRC_T1_DIN  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_BANK = 2'd1,
    DST_DOUT = 2'd2,
    DST_RSVD = 2'd3
  } dst_e;
endpackage

// File: rtl/twophase_regbank.sv
module twophase_regbank #(
  parameter int DW = 8,
  parameter int RA = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RA-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [RA-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  localparam int DEPTH = 1 << RA;

  logic [DW-1:0] mem [DEPTH];

  // combinational read: a same-cycle write is not yet visible
  assign rdata = mem[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/twophase_p1_stage.sv
module twophase_p1_stage
  import twophase_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  src_e          src,
  input  logic [DW-1:0] bank_q,
  input  logic [DW-1:0] din,
  input  logic          clrt1,
  input  logic          ld_al,
  input  logic          ld_addr,
  output logic [DW-1:0] t1,
  output logic [DW-1:0] t2,
  output logic [2*DW-1:0] addr
);
  logic [DW-1:0]   al_q;
  logic [2*DW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t1     <= '0;
      t2     <= '0;
      al_q   <= '0;
      addr_q <= '0;
    end else begin
      if (clrt1)                   t1 <= '0;
      else if (src == SRC_T1_BANK) t1 <= bank_q;
      else if (src == SRC_T1_DIN)  t1 <= din;
      if (src == SRC_T2_BANK)      t2 <= bank_q;
      if (ld_al)                   al_q <= bank_q;
      if (ld_addr)                 addr_q <= {bank_q, al_q};
    end
  end

  // address visible in the issuing cycle, then held by the register
  assign addr = ld_addr ? {bank_q, al_q} : addr_q;
endmodule

// File: rtl/twophase_p2_stage.sv
module twophase_p2_stage
  import twophase_pkg::*;
#(
  parameter int DW  = 8,
  parameter int RA  = 4,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  dst_e           dst,
  input  logic [RA-1:0]  regsel,
  input  logic [OPW-1:0] aluop,
  input  logic           rd_req,
  input  logic           wr_req,
  input  logic [DW-1:0]  alu_res,
  output logic           we,
  output logic [RA-1:0]  waddr,
  output logic [DW-1:0]  wdata,
  output logic [OPW-1:0] alu_op,
  output logic [DW-1:0]  dout,
  output logic           rd,
  output logic           wr,
  output dst_e           p2_dst
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p2_dst <= DST_NONE;
      waddr  <= '0;
      alu_op <= '0;
      rd     <= 1'b0;
      wr     <= 1'b0;
      dout   <= '0;
    end else begin
      p2_dst <= dst;
      waddr  <= regsel;
      alu_op <= aluop;
      rd     <= rd_req;
      wr     <= wr_req;
      if (p2_dst == DST_DOUT) dout <= alu_res;
    end
  end

  assign we    = (p2_dst == DST_BANK);
  assign wdata = alu_res;
endmodule

// File: rtl/twophase_datapath.sv
module twophase_datapath
  import twophase_pkg::*;
#(
  parameter int DW  = 8,
  parameter int RA  = 4,
  parameter int OPW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ui_src,
  input  logic [RA-1:0]    ui_reg,
  input  logic [1:0]       ui_dst,
  input  logic [OPW-1:0]   ui_aluop,
  input  logic             ui_ld_al,
  input  logic             ui_ld_addr,
  input  logic             ui_rd,
  input  logic             ui_wr,
  input  logic             ui_io,
  input  logic             ui_clrt1,
  input  logic             ui_ei,
  input  logic             ui_di,
  input  logic [DW-1:0]    din,
  input  logic [DW-1:0]    alu_res,
  output logic [DW-1:0]    t1,
  output logic [DW-1:0]    t2,
  output logic [OPW-1:0]   alu_op,
  output logic [2*DW-1:0]  addr,
  output logic             vma,
  output logic             rd,
  output logic             wr,
  output logic             io,
  output logic [DW-1:0]    dout,
  output logic             inte
);
  logic [DW-1:0] bank_q;
  logic          bank_we;
  logic [RA-1:0] bank_waddr;
  logic [DW-1:0] bank_wdata;
  dst_e          p2_dst;

  twophase_regbank #(.DW(DW), .RA(RA)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .raddr(ui_reg), .rdata(bank_q),
    .we(bank_we), .waddr(bank_waddr), .wdata(bank_wdata)
  );

  twophase_p1_stage #(.DW(DW)) u_p1 (
    .clk(clk), .rst_n(rst_n),
    .src(src_e'(ui_src)), .bank_q(bank_q), .din(din),
    .clrt1(ui_clrt1), .ld_al(ui_ld_al), .ld_addr(ui_ld_addr),
    .t1(t1), .t2(t2), .addr(addr)
  );

  twophase_p2_stage #(.DW(DW), .RA(RA), .OPW(OPW)) u_p2 (
    .clk(clk), .rst_n(rst_n),
    .dst(dst_e'(ui_dst)), .regsel(ui_reg), .aluop(ui_aluop),
    .rd_req(ui_rd), .wr_req(ui_wr), .alu_res(alu_res),
    .we(bank_we), .waddr(bank_waddr), .wdata(bank_wdata),
    .alu_op(alu_op), .dout(dout), .rd(rd), .wr(wr), .p2_dst(p2_dst)
  );

  // first-cycle strobes
  assign vma = ui_ld_addr;
  assign io  = ui_io;

  always_ff @(posedge clk) begin
    if (!rst_n)     inte <= 1'b0;
    else if (ui_di) inte <= 1'b0;
    else if (ui_ei) inte <= 1'b1;
  end
endmodule

// File: rtl/twophase_datapath_chk.sv
module twophase_datapath_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ui_rd,
  input logic          ui_ld_addr,
  input logic          ui_clrt1,
  input logic          ui_ei,
  input logic          ui_di,
  input logic [1:0]    p2_dst,
  input logic [DW-1:0] t1,
  input logic [DW-1:0] dout,
  input logic [2*DW-1:0] addr,
  input logic          rd,
  input logic          inte
);
  logic live;
  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  p_rd_second_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (rd == $past(ui_rd)));

  p_dout_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(p2_dst) != 2'd2) |-> $stable(dout));

  p_clear_t1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(ui_clrt1)) |-> (t1 == '0));

  p_di_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(ui_di)) |-> !inte);

  p_ei_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(ui_ei) && !$past(ui_di)) |-> inte);

  p_addr_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && rd && !ui_ld_addr) |-> $stable(addr));
endmodule

bind twophase_datapath twophase_datapath_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .ui_rd(ui_rd), .ui_ld_addr(ui_ld_addr),
  .ui_clrt1(ui_clrt1), .ui_ei(ui_ei), .ui_di(ui_di), .p2_dst(p2_dst),
  .t1(t1), .dout(dout), .addr(addr), .rd(rd), .inte(inte)
);

// File: tb/test_twophase_datapath.sv
module test_twophase_datapath;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ui_src, ui_dst;
  logic [3:0] ui_reg, ui_aluop, alu_op;
  logic ui_ld_al, ui_ld_addr, ui_rd, ui_wr, ui_io, ui_clrt1, ui_ei, ui_di;
  logic [7:0] din, alu_res, t1, t2, dout;
  logic [15:0] addr;
  logic vma, rd, wr, io, inte;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  // bench ALU model: op 1 adds, anything else passes T1
  assign alu_res = (alu_op == 4'd1) ? t1 + t2 : t1;

  twophase_datapath i_twophase_datapath (
    .clk(clk), .rst_n(rst_n), .ui_src(ui_src), .ui_reg(ui_reg), .ui_dst(ui_dst),
    .ui_aluop(ui_aluop), .ui_ld_al(ui_ld_al), .ui_ld_addr(ui_ld_addr),
    .ui_rd(ui_rd), .ui_wr(ui_wr), .ui_io(ui_io), .ui_clrt1(ui_clrt1),
    .ui_ei(ui_ei), .ui_di(ui_di), .din(din), .alu_res(alu_res),
    .t1(t1), .t2(t2), .alu_op(alu_op), .addr(addr), .vma(vma), .rd(rd),
    .wr(wr), .io(io), .dout(dout), .inte(inte)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_fields();
    ui_src = 2'd0; ui_dst = 2'd0; ui_reg = 4'd0; ui_aluop = 4'd0;
    ui_ld_al = 0; ui_ld_addr = 0; ui_rd = 0; ui_wr = 0; ui_io = 0;
    ui_clrt1 = 0; ui_ei = 0; ui_di = 0; din = 8'h00;
  endtask

  task automatic next();
    @(negedge clk);
    idle_fields();
  endtask

  task automatic write_reg(input logic [3:0] r, input logic [7:0] v);
    next(); ui_src = 2'd3; din = v; ui_reg = r; ui_dst = 2'd1;
    next();
    next();
  endtask

  task automatic read_t2(input logic [3:0] r, output logic [7:0] v);
    next(); ui_src = 2'd2; ui_reg = r;
    next(); v = t2;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk(t1 == 0 && t2 == 0 && dout == 0, "R1 latches", {t1, t2}, 16'h0);
    chk(addr == 0 && alu_op == 0 && !inte, "R1 addr/op/inte", addr, 16'h0);
    chk(!vma && !rd && !wr && !io, "R1 strobes", {vma, rd, wr, io}, 16'h0);
    read_t2(4'd9, v);
    chk(v == 8'h00, "R1 bank entry", v, 16'h0);
  endtask

  task automatic t_hazard();
    next(); ui_src = 2'd3; din = 8'h5A; ui_reg = 4'd3; ui_dst = 2'd1;
    next();
    chk(t1 == 8'h5A, "R2 T1 from din", t1, 16'h5A);
    ui_src = 2'd2; ui_reg = 4'd3;
    next();
    chk(t2 == 8'h00, "R4 old value seen by N+1", t2, 16'h00);
    chk(t1 == 8'h5A, "R2 T1 kept on T2 load", t1, 16'h5A);
    ui_src = 2'd2; ui_reg = 4'd3;
    next();
    chk(t2 == 8'h5A, "R4 new value seen by N+2", t2, 16'h5A);
  endtask

  task automatic t_phase2_op();
    logic [7:0] v;
    next(); ui_src = 2'd3; din = 8'h03; ui_reg = 4'd6; ui_dst = 2'd1; ui_aluop = 4'd1;
    next();
    chk(alu_op == 4'd1, "R3 opcode in second cycle", alu_op, 16'd1);
    next();
    chk(alu_op == 4'd0, "R3 opcode follows next uinst", alu_op, 16'd0);
    read_t2(4'd6, v);
    chk(v == 8'h5D, "R3 bank written with ALU result", v, 16'h5D);
    next(); ui_src = 2'd1; ui_reg = 4'd6;
    next();
    chk(t1 == 8'h5D, "R2 T1 from bank", t1, 16'h5D);
  endtask

  task automatic t_dout();
    next(); ui_src = 2'd3; din = 8'h33; ui_dst = 2'd2;
    next();
    chk(dout == 8'h00, "R5 dout not yet written", dout, 16'h00);
    next();
    chk(dout == 8'h33, "R5 dout written in phase 2", dout, 16'h33);
    write_reg(4'd7, 8'h44);
    chk(dout == 8'h33, "R5 dout held over bank write", dout, 16'h33);
    next(); ui_src = 2'd3; din = 8'h99; ui_dst = 2'd2;
    next(); next();
    chk(dout == 8'h99, "R5 dout rewritten", dout, 16'h99);
  endtask

  task automatic t_address();
    write_reg(4'd4, 8'h12);
    write_reg(4'd5, 8'hAB);
    next(); ui_reg = 4'd4; ui_ld_al = 1;
    next(); ui_reg = 4'd5; ui_ld_addr = 1; ui_rd = 1;
    #1;
    chk(vma && !rd, "R7 vma first cycle, rd not yet", {vma, rd}, 16'h2);
    chk(addr == 16'hAB12, "R6 address formed", addr, 16'hAB12);
    next(); #1;
    chk(rd && !vma, "R7 rd second cycle", {vma, rd}, 16'h1);
    chk(addr == 16'hAB12, "R6 address held", addr, 16'hAB12);
    next(); ui_reg = 4'd5; ui_ld_al = 1;
    next(); ui_reg = 4'd4; ui_ld_addr = 1; ui_wr = 1; ui_io = 1;
    #1;
    chk(io && !wr, "R7 io first cycle, wr not yet", {io, wr}, 16'h2);
    chk(addr == 16'h12AB, "R6 swapped address", addr, 16'h12AB);
    next(); #1;
    chk(wr && !io && !rd, "R7 wr second cycle", {io, wr, rd}, 16'h2);
    next(); #1;
    chk(!wr, "R7 wr drops", wr, 16'h0);
  endtask

  task automatic t_clear();
    next(); ui_src = 2'd3; din = 8'hFF; ui_clrt1 = 1;
    next();
    chk(t1 == 8'h00, "R8 clear overrides load", t1, 16'h00);
    ui_src = 2'd3; din = 8'h81;
    next();
    chk(t1 == 8'h81, "R8 reload after clear", t1, 16'h81);
    ui_clrt1 = 1;
    next();
    chk(t1 == 8'h00, "R8 clear alone", t1, 16'h00);
  endtask

  task automatic t_inte();
    next(); ui_ei = 1;
    next();
    chk(inte, "R9 ei sets", inte, 16'h1);
    next();
    chk(inte, "R9 inte holds", inte, 16'h1);
    ui_ei = 1; ui_di = 1;
    next();
    chk(!inte, "R9 di wins over ei", inte, 16'h0);
    ui_ei = 1;
    next(); ui_di = 1;
    next();
    chk(!inte, "R9 di clears", inte, 16'h0);
  endtask

  initial begin
    idle_fields();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hazard();
    t_phase2_op();
    t_dout();
    t_address();
    t_clear();
    t_inte();
    next();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule